// File: doc/BRIEF.md
# Byte-to-Word Packing Stream Buffer

This block sits between the byte-wide peripheral side of one transfer stream and its word-wide memory side. It has two modes. In pass-through mode, every peripheral byte goes straight to the memory side as a single beat, in the same cycle, and nothing is stored. In packing mode, bytes collect in a 16-byte store (four 32-bit words). They are merged four at a time into words. Once the number of stored bytes reaches a programmed level, the memory side drains them as an incrementing burst.

Each block of data ends with a byte marked as the last one. After that byte, whatever remains in the store goes out as single beats, and byte strobes flag the lanes that carry no data. A sticky error flag records two faults: a write attempted into a full store, and a block whose byte count is not a whole multiple of the programmed fill level.

Both data sides are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. On the memory side, once a beat is offered in packing mode, it is held with the same data and strobes until it is taken. The peripheral side sees ready low while the store is full, and while a flush is in progress. In pass-through mode, the peripheral ready is the memory ready. Configuration and the clear strobe are plain level and pulse pins.

Top module: `strm_pack_fifo`

## Requirements
- R1: After reset, no memory beat is offered, the error flag is low, and in packing mode the peripheral side is ready.
- R2: In pass-through mode (`fifo_en`=0), `m_valid` equals `s_valid` and `s_ready` equals `m_ready`. Each beat carries the byte in bits 7:0 with the upper bits zero, `m_strb`=4'b0001 and `m_first`=1. The error flag is not changed.
- R3: In packing mode, four consecutive accepted bytes form one word. The earliest byte sits in bits 7:0 and the latest in bits 31:24.
- R4: `fill_lvl` selects the drain level: 0 = 4 bytes, 1 = 8 bytes, 2 = 12 bytes, 3 = 16 bytes. Outside a flush, no burst starts until the stored byte count is at least that level.
- R5: A burst has as many beats as the level has words (1 to 4). `m_first` is high on the first beat only, and every burst beat has `m_strb`=4'hF.
- R6: With 16 bytes stored, `s_ready` is low. A write offered while full, outside a flush, is not accepted and sets the error flag.
- R7: Once the last byte of a block is accepted, `s_ready` stays low until the store is empty. Any burst already running completes first. The remaining bytes then leave as single beats, each with `m_first`=1. A partial word has `m_strb` bits set only for the filled lanes, from lane 0 upward.
- R8: When the last byte is accepted, the error flag is set if the block's total byte count is not a multiple of the selected level.
- R9: The error flag stays set until a cycle with `err_clr` high and no new error event. A new error in the same cycle as the clear wins.
- R10: In packing mode, a beat offered and not taken is offered again on the next cycle with unchanged data and strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = packing mode, 0 = pass-through |
| fill_lvl | input | 2 | Drain level code |
| err_clr | input | 1 | Clear strobe for the error flag |
| s_valid | input | 1 | Peripheral byte valid |
| s_ready | output | 1 | Peripheral byte accepted when high with valid |
| s_data | input | 8 | Peripheral byte |
| s_last | input | 1 | Marks the last byte of a block |
| m_valid | output | 1 | Memory beat valid |
| m_ready | input | 1 | Memory side takes the beat |
| m_data | output | 32 | Memory beat data |
| m_strb | output | 4 | Byte lanes holding data |
| m_first | output | 1 | First beat of a burst (every single beat) |
| err | output | 1 | Sticky error flag |

## Verification
The hold and overflow properties assume three things about the inputs. `fifo_en` and `fill_lvl` change only while the store is empty and no beat is offered. `fill_lvl` stays constant for a whole block. `s_valid` is only a request, so a byte may be offered again later. The stimulus changes configuration only after a complete drain, with every input idle. The memory-side ready is randomised to cover stalls at every burst position and during flushes. Peripheral bytes are offered again until they are accepted.

// File: rtl/pkf_pkg.sv
package pkf_pkg;
  localparam int LANES_DEF = 4;
  localparam int DEPTH_WORDS_DEF = 4;

  typedef logic [7:0] byte_t;

  // words per burst for a fill level code (quarter steps of the depth)
  function automatic int thr_words(input logic [1:0] code, input int depth_words);
    return (int'(code) + 1) * depth_words / 4;
  endfunction
endpackage

// File: rtl/pkf_store.sv
module pkf_store
  import pkf_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int DEPTH_WORDS = DEPTH_WORDS_DEF,
  localparam int DB = LANES * DEPTH_WORDS,
  localparam int CW = $clog2(DB + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  byte_t              push_byte,
  input  logic               pop,
  output logic [CW-1:0]      count,
  output logic [8*LANES-1:0] rd_word
);
  localparam int PW = $clog2(DB);
  localparam int RW = $clog2(DEPTH_WORDS);
  localparam int LB = $clog2(LANES);

  byte_t          mem [DB];
  logic [PW-1:0]  wptr;
  logic [RW-1:0]  rptr;
  logic [CW-1:0]  popped;
  logic [CW-1:0]  count_nx;

  always_comb begin
    popped = '0;
    if (pop) popped = (count < CW'(LANES)) ? count : CW'(LANES);
    count_nx = count + CW'(push) - popped;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      count <= count_nx;
      if (push) wptr <= wptr + PW'(1);
      if (pop) begin
        rptr <= rptr + RW'(1);
        // partial word leaves the store empty: realign the byte pointer
        if (count < CW'(LANES)) wptr <= {rptr + RW'(1), {LB{1'b0}}};
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rd_word[8*i +: 8] = mem[{rptr, LB'(i)}];
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count < CW'(DB));
  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/pkf_drain.sv
module pkf_drain
  import pkf_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int DEPTH_WORDS = DEPTH_WORDS_DEF,
  localparam int DB = LANES * DEPTH_WORDS,
  localparam int CW = $clog2(DB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fill_lvl,
  input  logic [CW-1:0]    count,
  input  logic             flushing,
  input  logic             m_ready,
  output logic             m_valid,
  output logic             m_first,
  output logic [LANES-1:0] m_strb,
  output logic             pop
);
  localparam int BW = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;

  logic [BW-1:0] beats_left;
  logic          busy;
  int            tw;
  logic [CW-1:0] thr_b;

  always_comb begin
    tw      = thr_words(fill_lvl, DEPTH_WORDS);
    thr_b   = CW'(tw * LANES);
    busy    = beats_left != '0;
    m_valid = busy || (flushing && count != '0) || (!flushing && count >= thr_b);
    m_first = !busy;
    pop     = m_valid && m_ready;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_strb
    assign m_strb[i] = busy || (count > CW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats_left <= '0;
    end else if (pop) begin
      if (busy)           beats_left <= beats_left - BW'(1);
      else if (!flushing) beats_left <= BW'(tw - 1);
    end
  end

  a_r5_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    int'(beats_left) < DEPTH_WORDS);
  a_r5_burst_beats_full: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> count >= CW'(LANES));
endmodule

// File: rtl/pkf_ctrl.sv
module pkf_ctrl
  import pkf_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int DEPTH_WORDS = DEPTH_WORDS_DEF,
  localparam int DB = LANES * DEPTH_WORDS,
  localparam int CW = $clog2(DB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    fill_lvl,
  input  logic          err_clr,
  input  logic          s_valid,
  input  logic          s_last,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] count,
  output logic          flushing,
  output logic          err
);
  localparam int KW = $clog2(DB);

  logic [KW-1:0] blk;
  logic [KW-1:0] blk_top;
  logic          full_hit;
  logic          short_hit;

  always_comb begin
    blk_top   = KW'(thr_words(fill_lvl, DEPTH_WORDS) * LANES - 1);
    full_hit  = fifo_en && s_valid && !flushing && count == CW'(DB);
    short_hit = push && s_last && blk != blk_top;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk      <= '0;
      flushing <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (push) begin
        if (s_last || blk == blk_top) blk <= '0;
        else                          blk <= blk + KW'(1);
      end
      if (push && s_last)                                flushing <= 1'b1;
      else if (flushing && pop && count <= CW'(LANES))   flushing <= 1'b0;
      if (full_hit || short_hit) err <= 1'b1;
      else if (err_clr)          err <= 1'b0;
    end
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !err_clr |=> err);
  a_r7_flush_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !push);
endmodule

// File: rtl/strm_pack_fifo.sv
module strm_pack_fifo
  import pkf_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int DEPTH_WORDS = DEPTH_WORDS_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic [1:0]         fill_lvl,
  input  logic               err_clr,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [7:0]         s_data,
  input  logic               s_last,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [8*LANES-1:0] m_data,
  output logic [LANES-1:0]   m_strb,
  output logic               m_first,
  output logic               err
);
  localparam int DB = LANES * DEPTH_WORDS;
  localparam int CW = $clog2(DB + 1);

  logic [CW-1:0]      count;
  logic [8*LANES-1:0] rd_word;
  logic               flushing;
  logic               f_valid, f_first, f_pop;
  logic [LANES-1:0]   f_strb;
  logic               push, pop;

  assign s_ready = fifo_en ? (!flushing && count < CW'(DB)) : m_ready;
  assign push    = fifo_en && s_valid && s_ready;
  assign pop     = fifo_en && f_pop;

  pkf_store #(.LANES(LANES), .DEPTH_WORDS(DEPTH_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_byte(s_data), .pop(pop),
    .count(count), .rd_word(rd_word)
  );

  pkf_drain #(.LANES(LANES), .DEPTH_WORDS(DEPTH_WORDS)) u_drain (
    .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .count(count),
    .flushing(flushing), .m_ready(m_ready && fifo_en), .m_valid(f_valid),
    .m_first(f_first), .m_strb(f_strb), .pop(f_pop)
  );

  pkf_ctrl #(.LANES(LANES), .DEPTH_WORDS(DEPTH_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fill_lvl(fill_lvl),
    .err_clr(err_clr), .s_valid(s_valid), .s_last(s_last), .push(push),
    .pop(pop), .count(count), .flushing(flushing), .err(err)
  );

  always_comb begin
    if (fifo_en) begin
      m_valid = f_valid;
      m_data  = rd_word;
      m_strb  = f_strb;
      m_first = f_first;
    end else begin
      m_valid = s_valid;
      m_data  = {{(8*LANES-8){1'b0}}, s_data};
      m_strb  = LANES'(1);
      m_first = 1'b1;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && m_valid && !m_ready |=>
      !fifo_en || (m_valid && $stable(m_data) && $stable(m_strb)));
  a_r6_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && count == CW'(DB) |-> !s_ready);
  a_r6_full_err: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && s_valid && !s_ready && !flushing && !m_ready |=> err);
endmodule

// File: tb/tb_strm_pack_fifo.sv
`timescale 1ns/1ps
module tb_strm_pack_fifo;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        fifo_en = 1;
  logic [1:0]  fill_lvl = 2'd3;
  logic        err_clr = 0;
  logic        s_valid = 0;
  logic        s_ready;
  logic [7:0]  s_data = 0;
  logic        s_last = 0;
  logic        m_valid;
  logic        m_ready = 0;
  logic [31:0] m_data;
  logic [3:0]  m_strb;
  logic        m_first;
  logic        err;

  strm_pack_fifo dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fill_lvl(fill_lvl),
    .err_clr(err_clr), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_strb(m_strb), .m_first(m_first), .err(err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  int stall_pct = 0;

  logic [7:0] mq[$];
  int   m_beats = 0;
  logic m_flush = 0;
  logic m_err = 0;
  int   m_blk = 0;
  logic accepted;

  function automatic void chk(string nm, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", cur_tag, nm, a, e);
    end
  endfunction

  task automatic step(input logic v, input logic [7:0] d, input logic l,
                      input logic r, input logic c);
    int cnt, thw, thb, np;
    logic emv, efirst, erdy, busy_b, fp, set_err;
    logic [3:0] estrb;
    s_valid = v; s_data = d; s_last = l; m_ready = r; err_clr = c;
    #1;
    cnt = mq.size(); thw = int'(fill_lvl) + 1; thb = thw * 4;
    busy_b = m_beats > 0;
    if (!fifo_en) begin
      emv = v; erdy = r; efirst = 1'b1; estrb = 4'b0001;
    end else begin
      emv = busy_b || (m_flush && cnt > 0) || (!m_flush && cnt >= thb);
      efirst = !busy_b;
      estrb = (busy_b || cnt >= 4) ? 4'hF : 4'((1 << cnt) - 1);
      erdy = !m_flush && cnt < 16;
    end
    chk("s_ready", 32'(s_ready), 32'(erdy));
    chk("m_valid", 32'(m_valid), 32'(emv));
    chk("err", 32'(err), 32'(m_err));
    if (emv) begin
      chk("m_first", 32'(m_first), 32'(efirst));
      chk("m_strb", 32'(m_strb), 32'(estrb));
      if (!fifo_en) chk("m_data", m_data, {24'b0, d});
      else for (int i = 0; i < 4; i++)
        if (estrb[i]) chk("m_data lane", 32'(m_data[8*i +: 8]), 32'(mq[i]));
    end
    accepted = v && erdy;
    set_err = 1'b0;
    if (fifo_en) begin
      set_err = v && !m_flush && cnt == 16;
      fp = m_flush;
      if (emv && r) begin
        np = (cnt < 4) ? cnt : 4;
        repeat (np) void'(mq.pop_front());
        if (busy_b) m_beats--;
        else if (!m_flush) m_beats = thw - 1;
      end
      if (accepted) begin
        mq.push_back(d);
        if (l) begin
          if (m_blk != thb - 1) set_err = 1'b1;
          m_blk = 0; m_flush = 1'b1;
        end else m_blk = (m_blk == thb - 1) ? 0 : m_blk + 1;
      end
      if (fp && mq.size() == 0) m_flush = 1'b0;
    end
    if (set_err) m_err = 1'b1;
    else if (c) m_err = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic rdy();
    return int'($urandom % 100) >= stall_pct;
  endfunction

  task automatic send(input logic [7:0] d, input logic l);
    int guard = 0;
    accepted = 0;
    while (!accepted && guard < 1000) begin
      step(1, d, l, rdy(), 0);
      guard++;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while ((mq.size() > 0 || m_beats > 0) && guard < 2000) begin
      step(0, 0, 0, rdy(), 0);
      guard++;
    end
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    cur_tag = "R1";
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);

    // R2: pass-through, ready follows memory side, last ignored
    cur_tag = "R2";
    fifo_en = 0;
    for (int i = 0; i < 8; i++) step(i % 3 != 2, 8'hA0 + 8'(i), i == 5, i % 2 == 0, 0);
    step(0, 0, 0, 1, 0);
    fifo_en = 1;

    // R4: full level, no drain below 16 bytes; R3 packing order
    fill_lvl = 2'd3; stall_pct = 0;
    cur_tag = "R4";
    for (int i = 0; i < 15; i++) send(8'h10 + 8'(i), 0);
    cur_tag = "R3";
    step(1, 8'h1F, 0, 0, 0);
    // R6: full, write refused, error set even with clear (R9 priority)
    cur_tag = "R6";
    step(0, 0, 0, 0, 0);
    cur_tag = "R9";
    step(1, 8'hEE, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    // R5 and R10: burst of four with stalls
    cur_tag = "R10"; stall_pct = 60;
    drain();
    cur_tag = "R9";
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);

    // R8 and R7: single last byte, bad count, single-lane flush
    cur_tag = "R8";
    send(8'h5A, 1);
    cur_tag = "R7";
    drain();
    step(0, 0, 0, 0, 1);

    // R5: half level, 10-byte block -> 2-beat burst then 2-byte flush, error
    fill_lvl = 2'd1; stall_pct = 40;
    cur_tag = "R5";
    for (int i = 0; i < 10; i++) send(8'h30 + 8'(i), i == 9);
    cur_tag = "R7";
    drain();
    step(0, 0, 0, 0, 1);

    // R8: quarter level, 8-byte block -> no error
    fill_lvl = 2'd0; stall_pct = 30;
    cur_tag = "R8";
    for (int i = 0; i < 8; i++) send(8'h60 + 8'(i), i == 7);
    drain();

    // R4: three-quarter level, 12-byte block
    fill_lvl = 2'd2; stall_pct = 0;
    cur_tag = "R4";
    for (int i = 0; i < 12; i++) send(8'h80 + 8'(i), i == 11);
    drain();

    // R7: three-quarter level, 7-byte block with stalls
    stall_pct = 50;
    cur_tag = "R7";
    for (int i = 0; i < 7; i++) send(8'hC0 + 8'(i), i == 6);
    drain();
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule